// File: doc/BRIEF.md
# Split-Permission Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations in a direct-mapped array. The slot for a page is picked by the low bits of its virtual page number. Each slot keeps three independent tags, one for each kind of access: instruction fetch, data load and data store. All three tags share one stored page offset. Because the tags are separate, a page can be cached as readable but not yet writable. A store to that page then misses, and the page table walker outside this block gets a chance to check write permission and set the dirty state before the store mapping is installed.

The lookup port is combinational. It takes a virtual address and an access kind and returns a hit flag and the translated physical address. The refill port takes a virtual page number, a physical page number and an access kind, and it writes on the next clock edge. A refill installs the tag of its own access kind. It also invalidates any sibling tag in that slot that holds a different page. The flush input invalidates every tag in one edge. It also sends a one-cycle invalidate request to the instruction cache.

Top module: `split_tlb`

## Requirements
- R1: After reset every tag is invalid, every lookup misses, and `icache_flush` is low.
- R2: The slot index is the virtual page number modulo `ENTRIES`, which is its low `log2(ENTRIES)` bits. The stored tag is the whole virtual page number, so two pages that share a slot evict each other and never alias.
- R3: Access kind codes are 0 for load, 1 for store, 2 for fetch, and 3 for load. A lookup hits only when the tag of its own kind in the indexed slot equals the virtual page number of the lookup address.
- R4: On a hit, `lk_paddr` is the physical page number stored at the last refill of that slot, followed by the low 12 address bits unchanged (the page size is 4 KiB). On a miss, `lk_paddr` is zero.
- R5: A refill writes the tag of its own access kind only. The other kinds do not gain a valid tag from it.
- R6: A refill sets each sibling tag in its slot that differs from the new virtual page number to all ones (invalid). A sibling tag that already equals the new page stays valid.
- R7: The physical page offset is shared per slot. A refill of any kind changes the translation returned for every kind that is still valid in that slot.
- R8: A flush sets all tags of all kinds to invalid. When a flush and a refill arrive in the same cycle, the flush wins and the refill leaves no trace.
- R9: `icache_flush` is high for exactly the cycle that follows each cycle in which `flush` is high.
- R10: Because the all-ones tag is the invalid code, a lookup whose virtual page number is all ones always misses, even after a refill of that page.
- R11: A refill is visible to lookups in the cycle right after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_acc | input | 2 | Lookup access kind (0 load, 1 store, 2 fetch, 3 load) |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | VA_W | Translated physical address, zero on a miss |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VA_W-12 | Refill virtual page number |
| rf_ppn | input | VA_W-12 | Refill physical page number |
| rf_acc | input | 2 | Refill access kind |
| flush | input | 1 | Invalidate all entries |
| icache_flush | output | 1 | Instruction cache invalidate request |

## Verification
Directed sequences check the following cases:
- A load refill followed by lookups of all four kind codes, which shows that each kind has its own tag.
- A same-page refill of a second kind, which separates a sibling that survives from one that is cleared, and shows the shared offset changing.
- A refill of a different page into the same slot, which shows replacement rather than aliasing.
- A flush in the same cycle as a refill.
- The all-ones page number.

Random traffic draws its pages from a small pool of slots and high bits, so hits, conflict evictions and sibling clears are all frequent. Every lookup's hit flag and address are compared with a reference model written from the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD     = 2'd0,
        ACC_STORE    = 2'd1,
        ACC_FETCH    = 2'd2,
        ACC_LOAD_ALT = 2'd3
    } acc_e;

    localparam int N_ACC = 3;

    // Map an access code to its tag slot: 0 load, 1 store, 2 fetch.
    function automatic logic [1:0] acc_slot(input logic [1:0] acc);
        case (acc)
            ACC_FETCH: acc_slot = 2'd2;
            ACC_STORE: acc_slot = 2'd1;
            default:   acc_slot = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
    parameter int ENTRIES = 256,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             rf_valid,
    input  logic             rf_own,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VPN_W-1:0] rd_tag
);

    typedef struct packed {
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
    } tag_state_t;

    tag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.tag = '1;
        end else if (rf_valid) begin
            if (rf_own) begin
                st_d.tag[rf_idx] = rf_vpn;
            end else if (st_q.tag[rf_idx] != rf_vpn) begin
                st_d.tag[rf_idx] = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tag <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_tag = st_q.tag[rd_idx];

    // R8: after a flush every slot reads invalid
    a_r8_flush_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rd_tag == '1));

    // R5: own-kind refill stores the page in its slot
    a_r5_own_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !flush && rf_own) ##1 (rd_idx == $past(rf_idx))
        |-> (rd_tag == $past(rf_vpn)));

    // R6: sibling tag is either cleared or already held the new page
    a_r6_sibling_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !flush && !rf_own) ##1 (rd_idx == $past(rf_idx))
        |-> (rd_tag == '1 || rd_tag == $past(rf_vpn)));

endmodule

// File: rtl/tlb_offset_array.sv
module tlb_offset_array #(
    parameter int ENTRIES = 256,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             rf_valid,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [VPN_W-1:0] rf_ppn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VPN_W-1:0] rd_off
);

    typedef struct packed {
        logic [ENTRIES-1:0][VPN_W-1:0] off;
    } off_state_t;

    off_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rf_valid && !flush) begin
            st_d.off[rf_idx] = rf_ppn - rf_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.off <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_off = st_q.off[rd_idx];

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
    input  logic [N_ACC-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]            off,
    input  logic [VA_W-1:0]             vaddr,
    input  logic [1:0]                  acc,
    output logic                        hit,
    output logic [VA_W-1:0]             paddr
);

    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] sel_tag;

    always_comb begin
        vpn     = vaddr[VA_W-1:PAGE_SHIFT];
        sel_tag = tags[acc_slot(acc)];
        hit     = (sel_tag == vpn) && (vpn != '1);
        paddr   = '0;
        if (hit) begin
            paddr = {vpn + off, vaddr[PAGE_SHIFT-1:0]};
        end
    end

endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int ENTRIES    = 256,
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    output logic             lk_hit,
    output logic [VA_W-1:0]  lk_paddr,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [VPN_W-1:0] rf_ppn,
    input  logic [1:0]       rf_acc,
    input  logic             flush,
    output logic             icache_flush
);

    typedef struct packed {
        logic icache_flush;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;

    logic [IDX_W-1:0]            rf_idx;
    logic [IDX_W-1:0]            lk_idx;
    logic [1:0]                  rf_slot;
    logic [N_ACC-1:0][VPN_W-1:0] rd_tags;
    logic [VPN_W-1:0]            rd_off;

    assign rf_idx  = rf_vpn[IDX_W-1:0];
    assign lk_idx  = lk_vaddr[PAGE_SHIFT +: IDX_W];
    assign rf_slot = acc_slot(rf_acc);

    for (genvar g = 0; g < N_ACC; g++) begin : g_tag
        tlb_tag_array #(
            .ENTRIES (ENTRIES),
            .VPN_W   (VPN_W)
        ) u_tag (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .rf_valid (rf_valid),
            .rf_own   (rf_slot == 2'(g)),
            .rf_idx   (rf_idx),
            .rf_vpn   (rf_vpn),
            .rd_idx   (lk_idx),
            .rd_tag   (rd_tags[g])
        );
    end

    tlb_offset_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W)
    ) u_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rf_valid (rf_valid),
        .rf_idx   (rf_idx),
        .rf_vpn   (rf_vpn),
        .rf_ppn   (rf_ppn),
        .rd_idx   (lk_idx),
        .rd_off   (rd_off)
    );

    tlb_lookup #(
        .VA_W       (VA_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_lookup (
        .tags  (rd_tags),
        .off   (rd_off),
        .vaddr (lk_vaddr),
        .acc   (lk_acc),
        .hit   (lk_hit),
        .paddr (lk_paddr)
    );

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.icache_flush = flush;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign icache_flush = ctl_q.icache_flush;

    // R9: icache request follows flush by one cycle
    a_r9_icache_follow: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> icache_flush);
    a_r9_icache_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> !icache_flush);

    // R10: the invalid code never produces a hit
    a_r10_no_ones_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_vaddr[VA_W-1:PAGE_SHIFT] != '1));

    // R3: a hit means the tag of the requested kind matched
    a_r3_kind_match: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (rd_tags[acc_slot(lk_acc)] == lk_vaddr[VA_W-1:PAGE_SHIFT]));

endmodule

// File: tb/split_tlb_tb_top.sv
`timescale 1ns/1ps
module split_tlb_tb_top;

    localparam int VA_W  = 32;
    localparam int PS    = 12;
    localparam int ENT   = 256;
    localparam int VPN_W = VA_W - PS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic [1:0]       lk_acc = '0;
    logic             lk_hit;
    logic [VA_W-1:0]  lk_paddr;
    logic             rf_valid = 1'b0;
    logic [VPN_W-1:0] rf_vpn = '0;
    logic [VPN_W-1:0] rf_ppn = '0;
    logic [1:0]       rf_acc = '0;
    logic             flush = 1'b0;
    logic             icache_flush;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [VPN_W-1:0] mtag [3][ENT];
    logic [VPN_W-1:0] moff [ENT];
    logic             prev_fl = 1'b0;

    always #2.5 clk = ~clk;

    split_tlb #(.VA_W(VA_W), .PAGE_SHIFT(PS), .ENTRIES(ENT)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .rf_valid(rf_valid),
        .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_acc(rf_acc), .flush(flush),
        .icache_flush(icache_flush)
    );

    function automatic int slot_of(input logic [1:0] a);
        return (a == 2'd2) ? 2 : (a == 2'd1) ? 1 : 0;
    endfunction

    function automatic logic exp_hit(input logic [VA_W-1:0] va, input logic [1:0] a);
        logic [VPN_W-1:0] v = va[VA_W-1:PS];
        return (v != '1) && (mtag[slot_of(a)][v % ENT] == v);
    endfunction

    function automatic logic [VA_W-1:0] exp_pa(input logic [VA_W-1:0] va, input logic [1:0] a);
        logic [VPN_W-1:0] v = va[VA_W-1:PS];
        if (!exp_hit(va, a)) return '0;
        return {v + moff[v % ENT], va[PS-1:0]};
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < ENT; i++) mtag[t][i] = '1;
        for (int i = 0; i < ENT; i++) moff[i] = '0;
    endtask

    // One cycle: drive at negedge, check outputs, then apply edge to the model.
    task automatic step(input logic rv, input logic [VPN_W-1:0] rvpn,
                        input logic [VPN_W-1:0] rppn, input logic [1:0] racc,
                        input logic fl, input logic [VA_W-1:0] lva,
                        input logic [1:0] lacc, input string req);
        logic eh;
        logic [VA_W-1:0] ep;
        @(negedge clk);
        rf_valid = rv; rf_vpn = rvpn; rf_ppn = rppn; rf_acc = racc;
        flush = fl; lk_vaddr = lva; lk_acc = lacc;
        #1;
        eh = exp_hit(lva, lacc);
        ep = exp_pa(lva, lacc);
        n_tests++;
        if (lk_hit !== eh || lk_paddr !== ep) begin
            n_fail++;
            $display("FAIL %s: va=%h acc=%0d hit=%b pa=%h expected hit=%b pa=%h",
                     req, lva, lacc, lk_hit, lk_paddr, eh, ep);
        end
        n_tests++;
        if (icache_flush !== prev_fl) begin
            n_fail++;
            $display("FAIL R9: icache_flush=%b expected %b", icache_flush, prev_fl);
        end
        @(posedge clk);
        if (fl) begin
            model_reset();
        end else if (rv) begin
            for (int t = 0; t < 3; t++) begin
                if (t == slot_of(racc)) mtag[t][rvpn % ENT] = rvpn;
                else if (mtag[t][rvpn % ENT] != rvpn) mtag[t][rvpn % ENT] = '1;
            end
            moff[rvpn % ENT] = rppn - rvpn;
        end
        prev_fl = fl;
    endtask

    task automatic look(input logic [VA_W-1:0] va, input logic [1:0] a, input string req);
        step(1'b0, '0, '0, 2'd0, 1'b0, va, a, req);
    endtask

    task automatic refill(input logic [VPN_W-1:0] v, input logic [VPN_W-1:0] p,
                          input logic [1:0] a, input string req);
        step(1'b1, v, p, a, 1'b0, {v, 12'h000}, a, req);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VPN_W-1:0] va_a, va_b, ones;
        void'($urandom(32'd12345));
        model_reset();
        ones = '1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        look(32'h0000_0123, 2'd0, "R1");
        look(32'h0001_0456, 2'd1, "R1");
        look(32'h0004_5789, 2'd2, "R1");

        // R11/R4/R5: load refill, then check all kinds
        va_a = 20'h00123;
        refill(va_a, 20'h0abcd, 2'd0, "R11");
        look({va_a, 12'h5a5}, 2'd0, "R4");
        look({va_a, 12'h5a5}, 2'd3, "R3");
        look({va_a, 12'h5a5}, 2'd1, "R5");
        look({va_a, 12'h5a5}, 2'd2, "R5");

        // R6/R7: store refill of same page keeps load, new offset shared
        refill(va_a, 20'h0f00f, 2'd1, "R6");
        look({va_a, 12'hfff}, 2'd0, "R7");
        look({va_a, 12'h001}, 2'd1, "R7");

        // R2/R6: different page in same slot evicts siblings
        va_b = va_a + 20'(ENT);
        refill(va_b, 20'h22222, 2'd2, "R2");
        look({va_b, 12'h010}, 2'd2, "R2");
        look({va_a, 12'h010}, 2'd0, "R6");
        look({va_a, 12'h010}, 2'd1, "R6");
        look({va_b, 12'h010}, 2'd0, "R2");

        // R8: flush wins over same-cycle refill
        refill(20'h00777, 20'h11111, 2'd0, "R8");
        step(1'b1, 20'h00888, 20'h33333, 2'd0, 1'b1, {va_b, 12'h0}, 2'd2, "R8");
        look({20'h00888, 12'h0}, 2'd0, "R8");
        look({20'h00777, 12'h0}, 2'd0, "R8");
        look({va_b, 12'h0}, 2'd2, "R8");

        // R10: all-ones page never hits
        refill(ones, 20'h12345, 2'd0, "R10");
        look({ones, 12'h234}, 2'd0, "R10");

        // Random traffic over a small pool of slots
        for (int n = 0; n < 4000; n++) begin
            logic [VPN_W-1:0] rv_vpn, lv_vpn;
            int r = $urandom_range(0, 63);
            rv_vpn = VPN_W'({$urandom_range(0, 3), 8'($urandom_range(0, 7))});
            lv_vpn = VPN_W'({$urandom_range(0, 3), 8'($urandom_range(0, 7))});
            if ($urandom_range(0, 99) == 0) lv_vpn = ones;
            step((r < 24), rv_vpn, VPN_W'($urandom), 2'($urandom),
                 (r == 63), {lv_vpn, 12'($urandom)}, 2'($urandom), "R3/R4 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule